// File: doc/BRIEF.md
# Lazy Condition-Flag Evaluator

This block keeps the description of the last flag-producing operation, not the flags themselves. A writer stores a 4-bit operation code and three 64-bit operand words in one cycle. A query side rebuilds the negative, zero, carry and overflow flags from that record whenever they are needed. The operations covered are register copy, add, subtract, add-with-carry, subtract-with-carry and logical, each in a 32-bit and a 64-bit form.

Three results come out combinationally from the stored record. The first is the packed four-flag nibble inside a 64-bit word. The second is the carry flag alone. The third is the truth of a condition code. The condition query takes an 8-bit selector whose high nibble is the condition and whose low nibble is the operation code. The flags it tests are rebuilt for that operation code, applied to the stored operand words. A caller that passes the code it wrote therefore gets the condition of the last operation. The block does not decode instructions, and it does not model multiply or saturation flags.

Top module: `flag_thunk_eval`

## Requirements
- R1: When `wr_en` is high at a rising clock edge, the operation code and all three operand words are stored together. While `wr_en` is low the stored record, and so every output that depends on it, holds. Synchronous reset stores code 0 with zero operands, so `nzcv_word` and `carry_word` read zero.
- R2: `nzcv_word` carries N at bit 31, Z at bit 30, C at bit 29 and V at bit 28. All other bits are zero.
- R3: Code 0 (copy) passes bits 31:28 of operand word 1 straight through as N, Z, C and V.
- R4: Codes 1 (add, 32-bit), 2 (add, 64-bit), 5 (add-with-carry, 32-bit) and 6 (add-with-carry, 64-bit) add operand word 1 and operand word 2. Codes 5 and 6 also add bit 0 of operand word 3. N is the top bit of the result and Z is high when the result is zero. C is the unsigned carry out, and V is signed overflow.
- R5: Codes 3 (sub, 32-bit), 4 (sub, 64-bit), 7 (sub-with-carry, 32-bit) and 8 (sub-with-carry, 64-bit) compute word 1 minus word 2. Codes 7 and 8 also subtract one minus bit 0 of operand word 3. C is high when no borrow occurs, and V is signed overflow. For codes 1 to 8, every bit of operand word 3 apart from bit 0 is ignored. Codes 1 to 4 ignore operand word 3 entirely.
- R6: The 32-bit forms (codes 1, 3, 5, 7, 9) use only bits 31:0 of the operands. N is taken from bit 31, and carry and overflow are formed at 32 bits. Bits 63:32 have no effect.
- R7: Codes 9 (logical, 32-bit) and 10 (logical, 64-bit) treat operand word 1 as the finished result. N is its top bit, Z is high when it is zero, and C and V read zero. Operand words 2 and 3 are ignored.
- R8: Codes 11 to 15 yield all four flags zero.
- R9: `carry_word` holds the C flag in bit 0 and zero in bits 63:1.
- R10: `cond_word` bit 0 is the truth of condition `q_sel[7:4]`. The flags it tests are rebuilt for operation code `q_sel[3:0]` from the stored operand words. Bits 63:1 are zero.
- R11: The conditions decode as follows. 0 is Z and 1 is !Z. 2 is C and 3 is !C. 4 is N and 5 is !N. 6 is V and 7 is !V. 8 is C&&!Z and 9 is !C||Z. 10 is N==V and 11 is N!=V. 12 is !Z&&N==V and 13 is Z||N!=V. 14 and 15 are always true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Store a new operation record |
| wr_op | input | 4 | Operation code to store |
| wr_arg1 | input | 64 | Operand word 1 (left argument, result, or packed flags) |
| wr_arg2 | input | 64 | Operand word 2 (right argument) |
| wr_arg3 | input | 64 | Operand word 3 (previous carry in bit 0) |
| q_sel | input | 8 | Condition query selector: condition in 7:4, operation code in 3:0 |
| nzcv_word | output | 64 | Packed flags at bits 31:28 |
| carry_word | output | 64 | Carry flag at bit 0 |
| cond_word | output | 64 | Condition truth at bit 0 |

## Verification
The checker assumes that `wr_en` is low while reset is asserted, so that the cycle after reset never holds a copy-pass write. It also assumes that a write's operand words are stable at the edge that stores them. The bench drives every input on the falling edge and keeps `wr_en` low through reset. It sweeps all sixteen operation codes over corner operands and three previous-carry words, and after each write it tests all sixteen conditions. Upper-half garbage sits in the 32-bit operands to show it has no effect.

// File: rtl/flag_thunk_pkg.sv
package flag_thunk_pkg;

    localparam int WORD_W   = 64;
    localparam int HALF_W   = 32;
    localparam int OP_W     = 4;
    localparam int COND_W   = 4;
    localparam int SEL_W    = OP_W + COND_W;
    localparam int FLAG_LSB = 28;

    localparam logic [OP_W-1:0] OP_COPY    = 4'd0;
    localparam logic [OP_W-1:0] OP_ADD32   = 4'd1;
    localparam logic [OP_W-1:0] OP_ADD64   = 4'd2;
    localparam logic [OP_W-1:0] OP_SUB32   = 4'd3;
    localparam logic [OP_W-1:0] OP_SUB64   = 4'd4;
    localparam logic [OP_W-1:0] OP_ADC32   = 4'd5;
    localparam logic [OP_W-1:0] OP_ADC64   = 4'd6;
    localparam logic [OP_W-1:0] OP_SBC32   = 4'd7;
    localparam logic [OP_W-1:0] OP_SBC64   = 4'd8;
    localparam logic [OP_W-1:0] OP_LOGIC32 = 4'd9;
    localparam logic [OP_W-1:0] OP_LOGIC64 = 4'd10;

    typedef enum logic [COND_W-1:0] {
        CND_EQ = 4'd0,  CND_NE = 4'd1,  CND_HS = 4'd2,  CND_LO = 4'd3,
        CND_MI = 4'd4,  CND_PL = 4'd5,  CND_VS = 4'd6,  CND_VC = 4'd7,
        CND_HI = 4'd8,  CND_LS = 4'd9,  CND_GE = 4'd10, CND_LT = 4'd11,
        CND_GT = 4'd12, CND_LE = 4'd13, CND_AL = 4'd14, CND_NV = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [WORD_W-1:0] arg1;
        logic [WORD_W-1:0] arg2;
        logic [WORD_W-1:0] arg3;
    } thunk_t;

    typedef struct packed {
        logic is_copy;
        logic is_arith;
        logic is_sub;
        logic take_carry;
        logic is_logic;
        logic wide;
    } op_ctl_t;

    function automatic op_ctl_t decode_op(input logic [OP_W-1:0] op);
        op_ctl_t c;
        c = '0;
        case (op)
            OP_COPY:    c.is_copy = 1'b1;
            OP_ADD32:   c.is_arith = 1'b1;
            OP_ADD64:   begin c.is_arith = 1'b1; c.wide = 1'b1; end
            OP_SUB32:   begin c.is_arith = 1'b1; c.is_sub = 1'b1; end
            OP_SUB64:   begin c.is_arith = 1'b1; c.is_sub = 1'b1; c.wide = 1'b1; end
            OP_ADC32:   begin c.is_arith = 1'b1; c.take_carry = 1'b1; end
            OP_ADC64:   begin c.is_arith = 1'b1; c.take_carry = 1'b1; c.wide = 1'b1; end
            OP_SBC32:   begin c.is_arith = 1'b1; c.is_sub = 1'b1; c.take_carry = 1'b1; end
            OP_SBC64:   begin
                c.is_arith = 1'b1; c.is_sub = 1'b1; c.take_carry = 1'b1; c.wide = 1'b1;
            end
            OP_LOGIC32: c.is_logic = 1'b1;
            OP_LOGIC64: begin c.is_logic = 1'b1; c.wide = 1'b1; end
            default:    c = '0;
        endcase
        return c;
    endfunction

    function automatic logic cond_holds(input logic [COND_W-1:0] cond, input flags_t f);
        logic r;
        case (cond_e'(cond))
            CND_EQ:  r = f.z;
            CND_NE:  r = !f.z;
            CND_HS:  r = f.c;
            CND_LO:  r = !f.c;
            CND_MI:  r = f.n;
            CND_PL:  r = !f.n;
            CND_VS:  r = f.v;
            CND_VC:  r = !f.v;
            CND_HI:  r = f.c && !f.z;
            CND_LS:  r = !f.c || f.z;
            CND_GE:  r = (f.n == f.v);
            CND_LT:  r = (f.n != f.v);
            CND_GT:  r = !f.z && (f.n == f.v);
            CND_LE:  r = f.z || (f.n != f.v);
            default: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/thunk_store.sv
module thunk_store
    import flag_thunk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  thunk_t wr_rec,
    output thunk_t rec_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else if (wr_en) begin
            rec_q <= wr_rec;
        end
    end
endmodule

// File: rtl/adder_flags.sv
module adder_flags
    import flag_thunk_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         invert_b,
    output flags_t       flags
);
    logic [W-1:0] b_eff;
    logic [W:0]   sum;
    logic [W-1:0] res;

    always_comb begin
        b_eff   = invert_b ? ~b : b;
        sum     = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        res     = sum[W-1:0];
        flags.n = res[W-1];
        flags.z = (res == '0);
        flags.c = sum[W];
        flags.v = (a[W-1] == b_eff[W-1]) && (res[W-1] != a[W-1]);
    end
endmodule

// File: rtl/flag_calc.sv
module flag_calc
    import flag_thunk_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [WORD_W-1:0] arg1,
    input  logic [WORD_W-1:0] arg2,
    input  logic [WORD_W-1:0] arg3,
    output flags_t            flags
);
    localparam int N_WIDTHS = 2;

    op_ctl_t ctl;
    logic    carry_in;
    flags_t  arith_f [N_WIDTHS];
    flags_t  logic_f;
    logic    unused_arg3_hi;

    assign ctl            = decode_op(op);
    assign carry_in       = ctl.take_carry ? arg3[0] : ctl.is_sub;
    assign unused_arg3_hi = ^arg3[WORD_W-1:1];

    for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
        localparam int GW = (g == 0) ? HALF_W : WORD_W;
        adder_flags #(.W(GW)) u_add (
            .a        (arg1[GW-1:0]),
            .b        (arg2[GW-1:0]),
            .cin      (carry_in),
            .invert_b (ctl.is_sub),
            .flags    (arith_f[g])
        );
    end

    always_comb begin
        logic_f.c = 1'b0;
        logic_f.v = 1'b0;
        if (ctl.wide) begin
            logic_f.n = arg1[WORD_W-1];
            logic_f.z = (arg1 == '0);
        end else begin
            logic_f.n = arg1[HALF_W-1];
            logic_f.z = (arg1[HALF_W-1:0] == '0);
        end
    end

    always_comb begin
        if (ctl.is_copy) begin
            flags = flags_t'(arg1[FLAG_LSB +: 4]);
        end else if (ctl.is_arith) begin
            flags = arith_f[ctl.wide ? 1 : 0];
        end else if (ctl.is_logic) begin
            flags = logic_f;
        end else begin
            flags = '0;
        end
    end
endmodule

// File: rtl/flag_thunk_eval.sv
module flag_thunk_eval
    import flag_thunk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  wr_op,
    input  logic [63:0] wr_arg1,
    input  logic [63:0] wr_arg2,
    input  logic [63:0] wr_arg3,
    input  logic [7:0]  q_sel,
    output logic [63:0] nzcv_word,
    output logic [63:0] carry_word,
    output logic [63:0] cond_word
);
    thunk_t          wr_rec;
    thunk_t          rec_q;
    flags_t          main_f;
    flags_t          query_f;
    logic [OP_W-1:0] held_op;

    assign wr_rec  = '{op: wr_op, arg1: wr_arg1, arg2: wr_arg2, arg3: wr_arg3};
    assign held_op = rec_q.op;

    thunk_store u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_rec (wr_rec),
        .rec_q  (rec_q)
    );

    flag_calc u_main (
        .op    (rec_q.op),
        .arg1  (rec_q.arg1),
        .arg2  (rec_q.arg2),
        .arg3  (rec_q.arg3),
        .flags (main_f)
    );

    flag_calc u_query (
        .op    (q_sel[OP_W-1:0]),
        .arg1  (rec_q.arg1),
        .arg2  (rec_q.arg2),
        .arg3  (rec_q.arg3),
        .flags (query_f)
    );

    always_comb begin
        nzcv_word                 = '0;
        nzcv_word[FLAG_LSB +: 4]  = main_f;
        carry_word                = '0;
        carry_word[0]             = main_f.c;
        cond_word                 = '0;
        cond_word[0]              = cond_holds(q_sel[SEL_W-1:OP_W], query_f);
    end
endmodule

// File: rtl/flag_thunk_chk.sv
module flag_thunk_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [3:0]  wr_op,
    input logic [3:0]  copy_nib,
    input logic [7:0]  q_sel,
    input logic [3:0]  held_op,
    input logic [63:0] nzcv_word,
    input logic [63:0] carry_word,
    input logic [63:0] cond_word
);
    // R1
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en)) |-> $stable(nzcv_word));

    // R2
    nzcv_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (nzcv_word[63:32] == 32'd0) && (nzcv_word[27:0] == 28'd0));

    // R3
    copy_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && ($past(wr_op) == 4'd0))
            |-> (nzcv_word[31:28] == $past(copy_nib)));

    // R7
    logic_clears_cv_chk: assert property (@(posedge clk) disable iff (rst)
        ((held_op == 4'd9) || (held_op == 4'd10)) |-> (nzcv_word[29:28] == 2'b00));

    // R8
    undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (held_op > 4'd10) |-> (nzcv_word == 64'd0));

    // R9
    carry_match_chk: assert property (@(posedge clk) disable iff (rst)
        carry_word == {63'd0, nzcv_word[29]});

    // R10
    cond_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cond_word[63:1] == 63'd0);

    // R11
    always_true_chk: assert property (@(posedge clk) disable iff (rst)
        (q_sel[7:5] == 3'b111) |-> cond_word[0]);

    // R11
    eq_matches_z_chk: assert property (@(posedge clk) disable iff (rst)
        (q_sel == {4'd0, held_op}) |-> (cond_word[0] == nzcv_word[30]));
endmodule

bind flag_thunk_eval flag_thunk_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_op      (wr_op),
    .copy_nib   (wr_arg1[31:28]),
    .q_sel      (q_sel),
    .held_op    (held_op),
    .nzcv_word  (nzcv_word),
    .carry_word (carry_word),
    .cond_word  (cond_word)
);

// File: tb/tb_flag_thunk_eval.sv
`timescale 1ns/1ps
module tb_flag_thunk_eval;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_op = '0;
    logic [63:0] wr_arg1 = '0, wr_arg2 = '0, wr_arg3 = '0;
    logic [7:0]  q_sel = '0;
    logic [63:0] nzcv_word, carry_word, cond_word;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    flag_thunk_eval dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_op(wr_op),
        .wr_arg1(wr_arg1), .wr_arg2(wr_arg2), .wr_arg3(wr_arg3),
        .q_sel(q_sel), .nzcv_word(nzcv_word), .carry_word(carry_word),
        .cond_word(cond_word)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pick(input int i);
        case (i)
            0: pick = 64'h0;
            1: pick = 64'h1;
            2: pick = 64'h7FFF_FFFF;
            3: pick = 64'h8000_0000;
            4: pick = 64'hFFFF_FFFF;
            5: pick = 64'h7FFF_FFFF_FFFF_FFFF;
            6: pick = 64'h8000_0000_0000_0000;
            7: pick = 64'hFFFF_FFFF_FFFF_FFFF;
            8: pick = 64'hA5A5_0000_0000_0000;
            default: pick = 64'h1234_5678_9000_0001;
        endcase
    endfunction

    // Reference flags as {N,Z,C,V}, computed by range arithmetic.
    function automatic logic [3:0] ref_flags(input int op, input logic [63:0] a,
                                             input logic [63:0] b, input logic [63:0] c);
        logic [65:0] am, bm, sa, sb, ss, us, r;
        logic        narrow, n, z, cf, vf, k;
        narrow = (op == 1) || (op == 3) || (op == 5) || (op == 7) || (op == 9);
        am = narrow ? {34'd0, a[31:0]} : {2'd0, a};
        bm = narrow ? {34'd0, b[31:0]} : {2'd0, b};
        sa = narrow ? {{34{a[31]}}, a[31:0]} : {{2{a[63]}}, a};
        sb = narrow ? {{34{b[31]}}, b[31:0]} : {{2{b[63]}}, b};
        k  = 1'b0;
        cf = 1'b0;
        ss = '0;
        us = '0;
        case (op)
            0: return a[31:28];
            1, 2, 5, 6: begin
                k  = (op >= 5) ? c[0] : 1'b0;
                us = am + bm + {65'd0, k};
                ss = sa + sb + {65'd0, k};
                cf = narrow ? us[32] : us[64];
            end
            3, 4, 7, 8: begin
                k  = (op >= 7) ? !c[0] : 1'b0;
                us = am - bm - {65'd0, k};
                ss = sa - sb - {65'd0, k};
                cf = (am >= bm + {65'd0, k});
            end
            9, 10: begin
                r = am;
                n = narrow ? r[31] : r[63];
                z = (r == '0);
                return {n, z, 2'b00};
            end
            default: return 4'b0000;
        endcase
        r  = narrow ? {34'd0, us[31:0]} : {2'd0, us[63:0]};
        n  = narrow ? r[31] : r[63];
        z  = (r == '0);
        vf = narrow ? !((ss[65:31] == '0) || (ss[65:31] == '1))
                    : !((ss[65:63] == '0) || (ss[65:63] == '1));
        return {n, z, cf, vf};
    endfunction

    function automatic logic ref_cond(input int cond, input logic [3:0] f);
        logic n, z, cf, v;
        {n, z, cf, v} = f;
        case (cond)
            0: return z;          1: return !z;
            2: return cf;         3: return !cf;
            4: return n;          5: return !n;
            6: return v;          7: return !v;
            8: return cf && !z;   9: return !cf || z;
            10: return n == v;    11: return n != v;
            12: return !z && (n == v);
            13: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    function automatic string req_of(input int op);
        if (op == 0) return "R3";
        if (op == 1 || op == 2 || op == 5 || op == 6) return "R4";
        if (op >= 3 && op <= 8) return "R5";
        if (op == 9 || op == 10) return "R7";
        return "R8";
    endfunction

    task automatic write_and_check(input int op, input logic [63:0] a,
                                   input logic [63:0] b, input logic [63:0] c);
        logic [3:0] f;
        f = ref_flags(op, a, b, c);
        @(negedge clk);
        wr_en = 1'b1; wr_op = 4'(op); wr_arg1 = a; wr_arg2 = b; wr_arg3 = c;
        @(negedge clk);
        wr_en = 1'b0;
        #0.5;
        // R2 R6 and per-op requirement
        check(req_of(op), nzcv_word, {32'd0, f, 28'd0});
        // R9
        check("R9", carry_word, {63'd0, f[1]});
        for (int cnd = 0; cnd < 16; cnd++) begin
            int other;
            other = (op + 3) % 16;
            q_sel = {4'(cnd), 4'(op)};
            #0.25;
            // R10 R11
            check("R11", cond_word, {63'd0, ref_cond(cnd, f)});
            q_sel = {4'(cnd), 4'(other)};
            #0.25;
            check("R10", cond_word, {63'd0, ref_cond(cnd, ref_flags(other, a, b, c))});
        end
        // R1: idle cycle with different inputs must not disturb the record
        wr_op = 4'(op + 1); wr_arg1 = ~a; wr_arg2 = ~b; wr_arg3 = ~c;
        @(negedge clk);
        #0.5;
        check("R1", nzcv_word, {32'd0, f, 28'd0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #0.5;
        // R1 reset state
        check("R1", nzcv_word, 64'd0);
        check("R1", carry_word, 64'd0);
        q_sel = 8'h00;
        #0.25;
        check("R11", cond_word, 64'd0);
        q_sel = 8'h10;
        #0.25;
        check("R11", cond_word, 64'd1);

        for (int op = 0; op < 16; op++) begin
            for (int i = 0; i < 10; i++) begin
                for (int j = 0; j < 10; j++) begin
                    for (int k = 0; k < 3; k++) begin
                        logic [63:0] cw;
                        cw = (k == 0) ? 64'h0 : (k == 1) ? 64'h1 : 64'hFFFF_FFFF_FFFF_FFFE;
                        write_and_check(op, pick(i), pick(j), cw);
                    end
                end
            end
        end

        // R3: copy with every flag nibble and noise elsewhere
        for (int v = 0; v < 16; v++) begin
            write_and_check(0, {32'hFFFF_FFFF, 4'(v), 28'hABCDEF1}, 64'hFF, 64'h1);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule